// File: doc/BRIEF.md
# Call and Return Stack Controller

This block is the stack engine of a small 8-bit microcontroller core. It owns an 8-bit stack pointer and a 256-byte on-chip RAM that holds the stack. It carries out byte push, byte pop, a short call, a long call, an interrupt-entry call, return and return-from-interrupt. Each one runs as a short multi-cycle sequence against the single-port RAM. Instruction decode happens outside the block. The core hands over an already decoded command code together with its operands: a data byte for a push, the address of the instruction after the call (the return address), an 11-bit short target and a 16-bit long target.

The stack grows toward higher addresses. A push first advances the pointer and then writes at the new location. A pop first reads at the pointer and then moves it back. Both calls save the return address as two bytes, low byte first. The short call keeps the top five bits of the return address and replaces the lower eleven with its operand. Every finished command raises `done` for one cycle. The new program counter, the popped byte, the pointer and the interrupt in-service flag are held in registers.

Top module: `stack_engine`

## Requirements
- R1: After a synchronous reset, `sp_out` is 07h, `pc_out` is 0000h, `pop_byte` is 00h, and `in_service` and `done` are 0.
- R2: Command code 1 (push) raises the pointer by 1 and then stores `push_byte` at the new pointer value. It ends with a `done` pulse.
- R3: Command code 2 (pop) reads the byte at the pointer into `pop_byte` and then lowers the pointer by 1. Push and pop behave last-in first-out.
- R4: The pointer wraps modulo 256. A push at FFh lands at 00h, and a pop at 00h leaves FFh. The pointer never moves by more than 1 in a single cycle.
- R5: Command code 3 (short call) raises the pointer by 2. `pc_out` becomes `next_pc[15:11]` concatenated with `short_tgt[10:0]`.
- R6: Command code 4 (long call) raises the pointer by 2, and `pc_out` becomes `long_tgt`.
- R7: A call stores `next_pc[7:0]` at the old pointer + 1 and `next_pc[15:8]` at the old pointer + 2. A pop straight after a call therefore returns the high byte first and then the low byte.
- R8: Command code 5 (return) pops the high byte and then the low byte. `pc_out` becomes {high, low}, and the pointer drops by 2.
- R9: Command code 7 (interrupt call) acts as a long call and sets `in_service`. Command code 6 (return from interrupt) acts as a return and clears `in_service`. `in_service` changes only in a `done` cycle.
- R10: A `cmd_valid` that arrives while a sequence is in progress is ignored. It causes no pointer change, no RAM write and no extra `done`.
- R11: `done` is high for exactly one cycle per command. `pc_out` and `pop_byte` change only in a cycle where `done` is high.
- R12: Command code 0 does nothing. It produces no `done` and changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle (taken only when idle) |
| cmd_code | input | 3 | Command code: 0 none, 1 push, 2 pop, 3 short call, 4 long call, 5 return, 6 return from interrupt, 7 interrupt call |
| push_byte | input | 8 | Byte to push |
| next_pc | input | 16 | Return address saved by a call |
| short_tgt | input | 11 | Short call target (low 11 PC bits) |
| long_tgt | input | 16 | Long and interrupt call target |
| pc_out | output | 16 | New program counter after a call or return |
| pop_byte | output | 8 | Byte returned by the last pop |
| sp_out | output | 8 | Current stack pointer |
| in_service | output | 1 | Interrupt in-service flag |
| done | output | 1 | One-cycle completion strobe |

## Verification
Two events can fall in the same cycle. One is the completion strobe of one sequence. The other is the arrival of the next command, which the controller must take because it is already idle in that cycle. The stimulus table walk issues every command in the very cycle the previous `done` is seen, so each vector checks pointer, PC, popped byte and flag after back-to-back acceptance. The opposite case is a second request presented one cycle into a push. It is judged by checking that the pointer rose only once, that no second strobe appears and that a later pop returns the first byte.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_SCALL = 3'd3,
    OP_LCALL = 3'd4,
    OP_RET   = 3'd5,
    OP_RETI  = 3'd6,
    OP_ICALL = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INC,
    ST_WR,
    ST_RD,
    ST_TAKE,
    ST_FIN
  } seq_e;

endpackage

// File: rtl/stk_ram.sv
module stk_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single port, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int          AW      = 8,
  parameter logic [7:0]  RST_VAL = 8'h07
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [AW-1:0] sp
);
  always_ff @(posedge clk) begin
    if (rst)      sp <= AW'(RST_VAL);
    else if (inc) sp <= sp + AW'(1);
    else if (dec) sp <= sp - AW'(1);
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int DW  = 8,
  parameter int PCW = 16,
  parameter int SW  = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic [2:0]     cmd_code,
  input  logic [DW-1:0]  push_byte,
  input  logic [PCW-1:0] next_pc,
  input  logic [SW-1:0]  short_tgt,
  input  logic [PCW-1:0] long_tgt,
  input  logic [DW-1:0]  ram_q,
  output logic           sp_inc,
  output logic           sp_dec,
  output logic           ram_we,
  output logic [DW-1:0]  ram_wdata,
  output logic [PCW-1:0] pc_out,
  output logic [DW-1:0]  pop_byte,
  output logic           in_service,
  output logic           done
);
  seq_e           st;
  op_e            op_q;
  op_e            cmd_op;
  logic           second_q;
  logic [DW-1:0]  byte_q, hi_q, lo_q;
  logic [PCW-1:0] ret_q, tgt_q;

  assign cmd_op = op_e'(cmd_code);

  assign sp_inc = (st == ST_INC);
  assign sp_dec = (st == ST_TAKE);
  assign ram_we = (st == ST_WR);

  // low return byte goes first, high byte second
  always_comb begin
    if (op_q == OP_PUSH)  ram_wdata = byte_q;
    else if (second_q)    ram_wdata = ret_q[PCW-1:DW];
    else                  ram_wdata = ret_q[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      op_q       <= OP_NOP;
      second_q   <= 1'b0;
      byte_q     <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
      ret_q      <= '0;
      tgt_q      <= '0;
      pc_out     <= '0;
      pop_byte   <= '0;
      in_service <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q     <= cmd_op;
            byte_q   <= push_byte;
            ret_q    <= next_pc;
            second_q <= 1'b0;
            tgt_q    <= (cmd_op == OP_SCALL) ? {next_pc[PCW-1:SW], short_tgt}
                                              : long_tgt;
            case (cmd_op)
              OP_PUSH, OP_SCALL, OP_LCALL, OP_ICALL: st <= ST_INC;
              OP_POP, OP_RET, OP_RETI:               st <= ST_RD;
              default:                               st <= ST_IDLE;
            endcase
          end
        end
        ST_INC: st <= ST_WR;
        ST_WR: begin
          if (op_q == OP_PUSH) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else if (!second_q) begin
            second_q <= 1'b1;
            st       <= ST_INC;
          end else begin
            st <= ST_FIN;
          end
        end
        ST_RD: st <= ST_TAKE;
        ST_TAKE: begin
          if (op_q == OP_POP) begin
            pop_byte <= ram_q;
            done     <= 1'b1;
            st       <= ST_IDLE;
          end else if (!second_q) begin
            hi_q     <= ram_q;
            second_q <= 1'b1;
            st       <= ST_RD;
          end else begin
            lo_q <= ram_q;
            st   <= ST_FIN;
          end
        end
        ST_FIN: begin
          pc_out <= (op_q == OP_RET || op_q == OP_RETI) ? {hi_q, lo_q} : tgt_q;
          if (op_q == OP_ICALL) in_service <= 1'b1;
          if (op_q == OP_RETI)  in_service <= 1'b0;
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stack_engine.sv
module stack_engine #(
  parameter int         AW     = 8,
  parameter int         DW     = 8,
  parameter int         PCW    = 16,
  parameter int         SW     = 11,
  parameter logic [7:0] SP_RST = 8'h07
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic [2:0]     cmd_code,
  input  logic [DW-1:0]  push_byte,
  input  logic [PCW-1:0] next_pc,
  input  logic [SW-1:0]  short_tgt,
  input  logic [PCW-1:0] long_tgt,
  output logic [PCW-1:0] pc_out,
  output logic [DW-1:0]  pop_byte,
  output logic [AW-1:0]  sp_out,
  output logic           in_service,
  output logic           done
);
  logic          sp_inc, sp_dec, ram_we;
  logic [DW-1:0] ram_wdata, ram_q;

  stk_ptr #(.AW(AW), .RST_VAL(SP_RST)) u_ptr (
    .clk (clk),
    .rst (rst),
    .inc (sp_inc),
    .dec (sp_dec),
    .sp  (sp_out)
  );

  stk_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .addr  (sp_out),
    .wdata (ram_wdata),
    .q     (ram_q)
  );

  stk_seq #(.DW(DW), .PCW(PCW), .SW(SW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .push_byte  (push_byte),
    .next_pc    (next_pc),
    .short_tgt  (short_tgt),
    .long_tgt   (long_tgt),
    .ram_q      (ram_q),
    .sp_inc     (sp_inc),
    .sp_dec     (sp_dec),
    .ram_we     (ram_we),
    .ram_wdata  (ram_wdata),
    .pc_out     (pc_out),
    .pop_byte   (pop_byte),
    .in_service (in_service),
    .done       (done)
  );
endmodule

// File: rtl/stk_chk.sv
module stk_chk #(
  parameter int AW  = 8,
  parameter int DW  = 8,
  parameter int PCW = 16
) (
  input logic           clk,
  input logic           rst,
  input logic [AW-1:0]  sp_out,
  input logic [PCW-1:0] pc_out,
  input logic [DW-1:0]  pop_byte,
  input logic           in_service,
  input logic           done
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc_out) |-> done);

  // R3
  pop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pop_byte) |-> done);

  // R9
  isr_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(in_service) |-> done);

  // R4
  sp_step_chk: assert property (@(posedge clk) disable iff (rst)
    (sp_out == $past(sp_out)) ||
    (sp_out == AW'($past(sp_out) + 1'b1)) ||
    (sp_out == AW'($past(sp_out) - 1'b1)));
endmodule

bind stack_engine stk_chk #(.AW(AW), .DW(DW), .PCW(PCW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sp_out     (sp_out),
  .pc_out     (pc_out),
  .pop_byte   (pop_byte),
  .in_service (in_service),
  .done       (done)
);

// File: tb/sim_stack_engine.sv
module sim_stack_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_code = 3'd0;
  logic [7:0]  push_byte = 8'h00;
  logic [15:0] next_pc = 16'h0000;
  logic [10:0] short_tgt = 11'h000;
  logic [15:0] long_tgt = 16'h0000;
  logic [15:0] pc_out;
  logic [7:0]  pop_byte;
  logic [7:0]  sp_out;
  logic        in_service;
  logic        done;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  stack_engine u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .push_byte(push_byte), .next_pc(next_pc), .short_tgt(short_tgt),
    .long_tgt(long_tgt), .pc_out(pc_out), .pop_byte(pop_byte),
    .sp_out(sp_out), .in_service(in_service), .done(done)
  );

  typedef struct packed {
    logic [2:0]  code;
    logic [7:0]  dat;
    logic [15:0] npc;
    logic [15:0] tgt;
    logic [7:0]  esp;
    logic [15:0] epc;
    logic [7:0]  erd;
    logic        eisr;
  } vec_t;

  localparam int NV = 11;
  // pops 9..11 read back the first long call high/low bytes (R7), then the first push
  localparam vec_t VEC [NV] = '{
    '{3'd1, 8'hA5, 16'h0000, 16'h0000, 8'h08, 16'h0000, 8'h00, 1'b0},
    '{3'd1, 8'h3C, 16'h0000, 16'h0000, 8'h09, 16'h0000, 8'h00, 1'b0},
    '{3'd2, 8'h00, 16'h0000, 16'h0000, 8'h08, 16'h0000, 8'h3C, 1'b0},
    '{3'd4, 8'h00, 16'h1234, 16'hABCD, 8'h0A, 16'hABCD, 8'h3C, 1'b0},
    '{3'd3, 8'h00, 16'hF9E8, 16'h0123, 8'h0C, 16'hF923, 8'h3C, 1'b0},
    '{3'd5, 8'h00, 16'h0000, 16'h0000, 8'h0A, 16'hF9E8, 8'h3C, 1'b0},
    '{3'd7, 8'h00, 16'h0456, 16'h0003, 8'h0C, 16'h0003, 8'h3C, 1'b1},
    '{3'd6, 8'h00, 16'h0000, 16'h0000, 8'h0A, 16'h0456, 8'h3C, 1'b0},
    '{3'd2, 8'h00, 16'h0000, 16'h0000, 8'h09, 16'h0456, 8'h12, 1'b0},
    '{3'd2, 8'h00, 16'h0000, 16'h0000, 8'h08, 16'h0456, 8'h34, 1'b0},
    '{3'd2, 8'h00, 16'h0000, 16'h0000, 8'h07, 16'h0456, 8'hA5, 1'b0}
  };

  function automatic string tag_of(input logic [2:0] c, input int idx);
    if (idx >= 8 && idx <= 9) return "R7";
    case (c)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [7:0] d,
                       input logic [15:0] npc, input logic [15:0] tgt);
    cmd_code  = c;
    push_byte = d;
    next_pc   = npc;
    short_tgt = tgt[10:0];
    long_tgt  = tgt;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    bit seen = 1'b0;
    for (int k = 0; k < 30 && !seen; k++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    if (!seen) chk(tag, "done seen", 32'd0, 32'd1);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1", "sp", 32'(sp_out), 32'h07);
    chk("R1", "pc", 32'(pc_out), 32'h0);
    chk("R1", "pop", 32'(pop_byte), 32'h0);
    chk("R1", "isr", 32'(in_service), 32'h0);
    chk("R1", "done", 32'(done), 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // table walk: each command issued in the cycle the previous done is seen
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].code, VEC[i].dat, VEC[i].npc, VEC[i].tgt);
      wait_done(tag_of(VEC[i].code, i));
      chk(tag_of(VEC[i].code, i), "sp",  32'(sp_out),     32'(VEC[i].esp));
      chk(tag_of(VEC[i].code, i), "pc",  32'(pc_out),     32'(VEC[i].epc));
      chk(tag_of(VEC[i].code, i), "pop", 32'(pop_byte),   32'(VEC[i].erd));
      chk(tag_of(VEC[i].code, i), "isr", 32'(in_service), 32'(VEC[i].eisr));
    end

    // R11 strobe lasts one cycle
    @(negedge clk);
    chk("R11", "done width", 32'(done), 32'h0);

    // R12 no-operation code
    begin
      int ndone = 0;
      issue(3'd0, 8'hEE, 16'hFFFF, 16'hFFFF);
      for (int k = 0; k < 6; k++) begin
        if (done) ndone++;
        @(negedge clk);
      end
      chk("R12", "done count", 32'(ndone), 32'd0);
      chk("R12", "sp", 32'(sp_out), 32'h07);
      chk("R12", "pc", 32'(pc_out), 32'h0456);
    end

    // R10 request during a running push is dropped
    begin
      int extra = 0;
      issue(3'd1, 8'h11, 16'h0, 16'h0);
      cmd_code  = 3'd1;
      push_byte = 8'h22;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_done("R10");
      chk("R10", "sp", 32'(sp_out), 32'h08);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk("R10", "extra done", 32'(extra), 32'd0);
      issue(3'd2, 8'h0, 16'h0, 16'h0);
      wait_done("R10");
      chk("R10", "pop byte", 32'(pop_byte), 32'h11);
      chk("R10", "sp", 32'(sp_out), 32'h07);
    end

    // R4 wrap both ways
    for (int k = 0; k < 248; k++) begin
      issue(3'd1, 8'(k), 16'h0, 16'h0);
      wait_done("R4");
    end
    chk("R4", "sp at top", 32'(sp_out), 32'hFF);
    issue(3'd1, 8'h5A, 16'h0, 16'h0);
    wait_done("R4");
    chk("R4", "sp wrap up", 32'(sp_out), 32'h00);
    issue(3'd2, 8'h0, 16'h0, 16'h0);
    wait_done("R4");
    chk("R4", "pop at 00", 32'(pop_byte), 32'h5A);
    chk("R4", "sp wrap down", 32'(sp_out), 32'hFF);
    issue(3'd2, 8'h0, 16'h0, 16'h0);
    wait_done("R3");
    chk("R3", "lifo byte", 32'(pop_byte), 32'hF7);
    chk("R3", "sp", 32'(sp_out), 32'hFE);

    summary();
  end
endmodule